// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block is one DMA channel. Software loads a source address, a destination address, a transfer count and a 16-bit control word through a small write port. The channel then moves data one unit at a time. Each unit is a read from the source followed by a write to the destination, both issued on a simple single-cycle master port. Bit 0 of the control word sets the unit size to a byte or a word.

Each address has its own pair of step bits, and each may move up, move down or stay fixed after every unit. The count drops by one per unit. The control word chooses what paces the transfers: no pacing, the source request line, the destination request line, or an internal timer request line. The terminal-count bit sets whether a paced run stops when the count reaches zero. A free-running run always stops there.

When a run stops at zero, the channel can raise an interrupt line. That line stays high until it is acknowledged or the control word is written again. After reset the channel is parked and starts nothing until it is programmed.

Top module: `dma_chan_seq`

## Requirements
- R1: Each transfer is one read cycle (`bus_req`=1, `bus_we`=0) at the source address, followed in the next cycle by one write cycle (`bus_we`=1) at the destination address. The write carries the data returned in the read cycle. `bus_word` equals control bit 0 (1 = word, 0 = byte).
- R2: After each transfer the destination address changes as follows. Control bit 13 set with bit 14 clear adds the step. Bit 14 set with bit 13 clear subtracts the step. Equal bits leave it unchanged. The step is 2 when control bit 0 is 1 and 1 when it is 0.
- R3: The source address steps in the same way, under control bit 10 (increment) and bit 11 (decrement).
- R4: During the read cycle `bus_mem` equals control bit 12. During the write cycle it equals control bit 15. A value of 1 selects memory and 0 selects I/O.
- R5: The count decreases by one on every transfer. With control bits 7:6 = 00 (free running), transfers run back to back and stop after the transfer that brings the count to 0, whatever the value of bit 9.
- R6: With bits 7:6 = 01, a transfer starts only while `src_drq` is high. With 10, it starts only while `dst_drq` is high. In both modes the run stops at count 0 when bit 9 is 1 and continues past 0 when bit 9 is 0.
- R7: Bits 7:6 = 11 with bit 4 clear parks the channel, so no transfer starts. Reset loads the control word 0x00C0, so the channel is parked after reset.
- R8: With control bit 4 set, bits 7:6 are ignored and each transfer waits for `tmr_drq`. The stop rule is the same as for the paced modes.
- R9: `irq` rises only when a run stops at count 0 with both bit 9 and bit 8 set. It never rises otherwise.
- R10: `irq` stays high until either `irq_ack` is pulsed or the control word is written. A control write also re-arms a channel that has stopped.
- R11: Write-port select codes are 0 for control, 1 for source address, 2 for destination address and 3 for count. The next transfer uses the written values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select (0 ctrl, 1 src, 2 dst, 3 count) |
| reg_wdata | input | AW | Register write data (control uses bits 15:0) |
| src_drq | input | 1 | Source-side transfer request |
| dst_drq | input | 1 | Destination-side transfer request |
| tmr_drq | input | 1 | Internal timer transfer request |
| irq_ack | input | 1 | Clears the interrupt request |
| bus_req | output | 1 | Bus cycle active this clock |
| bus_we | output | 1 | 1 = write cycle, 0 = read cycle |
| bus_mem | output | 1 | 1 = memory space, 0 = I/O space |
| bus_word | output | 1 | 1 = word unit, 0 = byte unit |
| bus_addr | output | AW | Bus address |
| bus_wdata | output | DW | Write data |
| bus_rdata | input | DW | Read data, valid in the read cycle |
| irq | output | 1 | Interrupt request |

## Verification
The channel runs in free-running mode, source-paced mode, destination-paced mode and timer-paced mode. It also runs in parked mode while every request line is held high. Comparing these shows which request line gates transfers in each mode, and that the lines of the other modes have no effect. Terminal-count on and off runs separate stopping at zero from wrapping past zero. Runs with the interrupt enable on and off separate a correct interrupt from a spurious one.

Seeded random runs in free-running mode mix all four step-bit codes per address with both unit sizes, both spaces, random start addresses and random counts. Each bus cycle is compared with a model of the address and data sequence kept in the bench.

// File: rtl/dma_chan_pkg.sv
`timescale 1ns/1ps
package dma_chan_pkg;

    typedef enum logic [1:0] {
        SYNC_FREE = 2'b00,
        SYNC_SRC  = 2'b01,
        SYNC_DST  = 2'b10,
        SYNC_OFF  = 2'b11
    } sync_e;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_SRC  = 2'd1,
        SEL_DST  = 2'd2,
        SEL_CNT  = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        XS_IDLE  = 2'd0,
        XS_READ  = 2'd1,
        XS_WRITE = 2'd2
    } xfer_state_e;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } step_e;

    // Per-address configuration: space and step bits
    typedef struct packed {
        logic mem;
        logic dec;
        logic inc;
    } side_cfg_t;

    // Decoded control word (only the bits the channel acts on)
    typedef struct packed {
        side_cfg_t dst;
        side_cfg_t src;
        logic      tc;
        logic      irq_en;
        sync_e     sync;
        logic      timer;
        logic      word;
    } ctrl_t;

    // Parked after reset: pacing code 11, everything else clear
    localparam ctrl_t CTRL_RESET = ctrl_t'(12'h00C);

    function automatic step_e step_of(input logic inc, input logic dec);
        if (inc && !dec)      return STEP_UP;
        else if (dec && !inc) return STEP_DOWN;
        else                  return STEP_HOLD;
    endfunction

endpackage

// File: rtl/dma_addr_reg.sv
`timescale 1ns/1ps
module dma_addr_reg
    import dma_chan_pkg::*;
#(
    parameter int AW = 20
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          adv,
    input  logic          inc,
    input  logic          dec,
    input  logic          word,
    output logic [AW-1:0] addr
);
    localparam logic [AW-1:0] UNIT = AW'(1);

    logic [AW-1:0] stride;
    logic [AW-1:0] nxt;

    assign stride = word ? (UNIT << 1) : UNIT;

    always_comb begin
        case (step_of(inc, dec))
            STEP_UP:   nxt = addr + stride;
            STEP_DOWN: nxt = addr - stride;
            default:   nxt = addr;
        endcase
    end

    // A software load takes priority over the end-of-transfer step
    always_ff @(posedge clk) begin
        if (rst)       addr <= '0;
        else if (load) addr <= load_val;
        else if (adv)  addr <= nxt;
    end
endmodule

// File: rtl/dma_count_unit.sv
`timescale 1ns/1ps
module dma_count_unit #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          adv,
    output logic [CW-1:0] count,
    output logic          last
);
    localparam logic [CW-1:0] ONE = CW'(1);

    // The transfer in flight brings the count to zero
    assign last = (count == ONE);

    always_ff @(posedge clk) begin
        if (rst)       count <= '0;
        else if (load) count <= load_val;
        else if (adv)  count <= count - ONE;
    end
endmodule

// File: rtl/dma_xfer_ctl.sv
`timescale 1ns/1ps
module dma_xfer_ctl
    import dma_chan_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        tc,
    input  logic        irq_en,
    input  sync_e       sync,
    input  logic        timer,
    input  logic        src_drq,
    input  logic        dst_drq,
    input  logic        tmr_drq,
    input  logic        irq_ack,
    input  logic        ctrl_wr,
    input  logic        cnt_last,
    output xfer_state_e state,
    output logic        xfer_done,
    output logic        irq
);
    logic want;
    logic halted;
    logic stop_rule;
    logic run_end;
    logic irq_set;

    // Pacing source: the timer line overrides the sync code
    always_comb begin
        if (timer) begin
            want = tmr_drq;
        end else begin
            case (sync)
                SYNC_FREE: want = 1'b1;
                SYNC_SRC:  want = src_drq;
                SYNC_DST:  want = dst_drq;
                default:   want = 1'b0;
            endcase
        end
    end

    assign stop_rule = tc | (!timer && (sync == SYNC_FREE));
    assign xfer_done = (state == XS_WRITE);
    assign run_end   = xfer_done & cnt_last & stop_rule;
    assign irq_set   = run_end & tc & irq_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= XS_IDLE;
        end else begin
            case (state)
                XS_IDLE:  if (want && !halted && !ctrl_wr) state <= XS_READ;
                XS_READ:  state <= XS_WRITE;
                default:  state <= XS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          halted <= 1'b0;
        else if (ctrl_wr) halted <= 1'b0;
        else if (run_end) halted <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)          irq <= 1'b0;
        else if (ctrl_wr) irq <= 1'b0;
        else if (irq_set) irq <= 1'b1;
        else if (irq_ack) irq <= 1'b0;
    end
endmodule

// File: rtl/dma_chan_seq.sv
`timescale 1ns/1ps
module dma_chan_seq
    import dma_chan_pkg::*;
#(
    parameter int AW = 20,
    parameter int DW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_we,
    input  logic [1:0]    reg_sel,
    input  logic [AW-1:0] reg_wdata,
    input  logic          src_drq,
    input  logic          dst_drq,
    input  logic          tmr_drq,
    input  logic          irq_ack,
    output logic          bus_req,
    output logic          bus_we,
    output logic          bus_mem,
    output logic          bus_word,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] bus_rdata,
    output logic          irq
);
    ctrl_t         ctrl_q;
    ctrl_t         ctrl_d;
    logic          ctrl_wr;
    logic          src_wr;
    logic          dst_wr;
    logic          cnt_wr;
    logic [AW-1:0] src_q;
    logic [AW-1:0] dst_q;
    logic [CW-1:0] cnt_q;
    logic          cnt_last;
    logic [DW-1:0] data_q;
    xfer_state_e   state;
    logic          xfer_done;

    assign ctrl_wr = reg_we && (reg_sel == SEL_CTRL);
    assign src_wr  = reg_we && (reg_sel == SEL_SRC);
    assign dst_wr  = reg_we && (reg_sel == SEL_DST);
    assign cnt_wr  = reg_we && (reg_sel == SEL_CNT);

    // Control word field positions
    always_comb begin
        ctrl_d.dst.mem = reg_wdata[15];
        ctrl_d.dst.dec = reg_wdata[14];
        ctrl_d.dst.inc = reg_wdata[13];
        ctrl_d.src.mem = reg_wdata[12];
        ctrl_d.src.dec = reg_wdata[11];
        ctrl_d.src.inc = reg_wdata[10];
        ctrl_d.tc      = reg_wdata[9];
        ctrl_d.irq_en  = reg_wdata[8];
        ctrl_d.sync    = sync_e'(reg_wdata[7:6]);
        ctrl_d.timer   = reg_wdata[4];
        ctrl_d.word    = reg_wdata[0];
    end

    always_ff @(posedge clk) begin
        if (rst)          ctrl_q <= CTRL_RESET;
        else if (ctrl_wr) ctrl_q <= ctrl_d;
    end

    dma_addr_reg #(.AW(AW)) u_src (
        .clk      (clk),
        .rst      (rst),
        .load     (src_wr),
        .load_val (reg_wdata),
        .adv      (xfer_done),
        .inc      (ctrl_q.src.inc),
        .dec      (ctrl_q.src.dec),
        .word     (ctrl_q.word),
        .addr     (src_q)
    );

    dma_addr_reg #(.AW(AW)) u_dst (
        .clk      (clk),
        .rst      (rst),
        .load     (dst_wr),
        .load_val (reg_wdata),
        .adv      (xfer_done),
        .inc      (ctrl_q.dst.inc),
        .dec      (ctrl_q.dst.dec),
        .word     (ctrl_q.word),
        .addr     (dst_q)
    );

    dma_count_unit #(.CW(CW)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (cnt_wr),
        .load_val (reg_wdata[CW-1:0]),
        .adv      (xfer_done),
        .count    (cnt_q),
        .last     (cnt_last)
    );

    dma_xfer_ctl u_ctl (
        .clk       (clk),
        .rst       (rst),
        .tc        (ctrl_q.tc),
        .irq_en    (ctrl_q.irq_en),
        .sync      (ctrl_q.sync),
        .timer     (ctrl_q.timer),
        .src_drq   (src_drq),
        .dst_drq   (dst_drq),
        .tmr_drq   (tmr_drq),
        .irq_ack   (irq_ack),
        .ctrl_wr   (ctrl_wr),
        .cnt_last  (cnt_last),
        .state     (state),
        .xfer_done (xfer_done),
        .irq       (irq)
    );

    // Read data is held for the write cycle that follows
    always_ff @(posedge clk) begin
        if (rst)                    data_q <= '0;
        else if (state == XS_READ)  data_q <= bus_rdata;
    end

    always_comb begin
        bus_req   = (state != XS_IDLE);
        bus_we    = (state == XS_WRITE);
        bus_mem   = bus_we ? ctrl_q.dst.mem : ctrl_q.src.mem;
        bus_addr  = bus_we ? dst_q : src_q;
        bus_word  = ctrl_q.word;
        bus_wdata = data_q;
    end
endmodule

// File: rtl/dma_chan_seq_chk.sv
`timescale 1ns/1ps
module dma_chan_seq_chk #(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          bus_req,
    input logic          bus_we,
    input logic          irq,
    input logic          irq_ack,
    input logic          reg_we,
    input logic [1:0]    reg_sel,
    input logic [CW-1:0] count_q,
    input logic          ctl_tc,
    input logic          ctl_irq_en,
    input logic [1:0]    ctl_sync,
    input logic          ctl_timer
);
    logic ctrl_wr;
    logic cnt_wr;
    assign ctrl_wr = reg_we && (reg_sel == 2'd0);
    assign cnt_wr  = reg_we && (reg_sel == 2'd3);

    p_write_follows_read_r1: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_we) |=> (bus_req && bus_we));

    p_write_has_read_r1: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_we) |-> $past(bus_req && !bus_we));

    p_count_step_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_we && !cnt_wr) |=> (count_q == CW'($past(count_q) - CW'(1))));

    p_parked_r7: assert property (@(posedge clk) disable iff (rst)
        (!bus_req && ctl_sync == 2'b11 && !ctl_timer && !ctrl_wr) |=> !bus_req);

    p_irq_cause_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(ctl_tc && ctl_irq_en && bus_req && bus_we && count_q == CW'(1)));

    p_irq_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (irq && !irq_ack && !ctrl_wr) |=> irq);

    p_irq_ctrl_clear_r10: assert property (@(posedge clk) disable iff (rst)
        ctrl_wr |=> !irq);
endmodule

bind dma_chan_seq dma_chan_seq_chk #(.CW(CW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_req    (bus_req),
    .bus_we     (bus_we),
    .irq        (irq),
    .irq_ack    (irq_ack),
    .reg_we     (reg_we),
    .reg_sel    (reg_sel),
    .count_q    (cnt_q),
    .ctl_tc     (ctrl_q.tc),
    .ctl_irq_en (ctrl_q.irq_en),
    .ctl_sync   (ctrl_q.sync),
    .ctl_timer  (ctrl_q.timer)
);

// File: tb/dma_chan_seq_test.sv
`timescale 1ns/1ps
module dma_chan_seq_test;
    localparam int AW = 20;
    localparam int DW = 16;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_we = 1'b0;
    logic [1:0]    reg_sel = 2'd0;
    logic [AW-1:0] reg_wdata = '0;
    logic          src_drq = 1'b0;
    logic          dst_drq = 1'b0;
    logic          tmr_drq = 1'b0;
    logic          irq_ack = 1'b0;
    logic          bus_req, bus_we, bus_mem, bus_word, irq;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata, bus_rdata;

    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    dma_chan_seq #(.AW(AW), .DW(DW), .CW(CW)) uut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .src_drq(src_drq), .dst_drq(dst_drq), .tmr_drq(tmr_drq), .irq_ack(irq_ack),
        .bus_req(bus_req), .bus_we(bus_we), .bus_mem(bus_mem), .bus_word(bus_word),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    function automatic logic [DW-1:0] mem_val(input logic [AW-1:0] a, input logic m);
        return a[15:0] ^ {a[19:16], 12'h000} ^ (m ? 16'hC3A5 : 16'h3C5A);
    endfunction

    assign bus_rdata = mem_val(bus_addr, bus_mem);

    function automatic logic [AW-1:0] nstep(input logic [AW-1:0] a, input bit inc, input bit dec, input bit w);
        if (inc && !dec)      return a + (w ? 20'd2 : 20'd1);
        else if (dec && !inc) return a - (w ? 20'd2 : 20'd1);
        else                  return a;
    endfunction

    function automatic logic [15:0] mk_ctrl(input bit dmem, input bit ddec, input bit dinc,
                                            input bit smem, input bit sdec, input bit sinc,
                                            input bit tc, input bit ie, input bit [1:0] sy,
                                            input bit tmr, input bit w);
        return {dmem, ddec, dinc, smem, sdec, sinc, tc, ie, sy, 1'b0, tmr, 3'b000, w};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // Transaction model
    logic [AW-1:0] exp_src, exp_dst;
    logic [DW-1:0] exp_data;
    bit c_sinc, c_sdec, c_dinc, c_ddec, c_smem, c_dmem, c_word;
    int xfers = 0;
    bit first_rd = 1'b0;

    always @(negedge clk) begin
        if (!rst && bus_req) begin
            if (!bus_we) begin
                if (first_rd) chk(bus_addr == exp_src, "R11 programmed source used", 32'(bus_addr), 32'(exp_src));
                first_rd = 1'b0;
                chk(bus_addr == exp_src, "R3 source address", 32'(bus_addr), 32'(exp_src));
                chk(bus_mem == c_smem, "R4 source space", 32'(bus_mem), 32'(c_smem));
                chk(bus_word == c_word, "R1 unit size", 32'(bus_word), 32'(c_word));
                exp_data = mem_val(exp_src, c_smem);
            end else begin
                chk(bus_addr == exp_dst, "R2 destination address", 32'(bus_addr), 32'(exp_dst));
                chk(bus_mem == c_dmem, "R4 destination space", 32'(bus_mem), 32'(c_dmem));
                chk(bus_wdata == exp_data, "R1 write data", 32'(bus_wdata), 32'(exp_data));
                exp_src = nstep(exp_src, c_sinc, c_sdec, c_word);
                exp_dst = nstep(exp_dst, c_dinc, c_ddec, c_word);
                xfers++;
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] sel, input logic [AW-1:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic setup(input logic [15:0] c, input logic [AW-1:0] s, input logic [AW-1:0] d, input logic [CW-1:0] n);
        wr(2'd0, 20'h000C0);
        wr(2'd1, s);
        wr(2'd2, d);
        wr(2'd3, 20'(n));
        exp_src = s; exp_dst = d;
        c_dmem = c[15]; c_ddec = c[14]; c_dinc = c[13];
        c_smem = c[12]; c_sdec = c[11]; c_sinc = c[10];
        c_word = c[0];
        xfers = 0; first_rd = 1'b1;
        wr(2'd0, 20'(c));
    endtask

    task automatic pulse_ack();
        @(negedge clk); irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0;
    endtask

    task automatic pulse_tmr();
        @(negedge clk); tmr_drq = 1'b1;
        @(negedge clk); tmr_drq = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R1..all act=timeout exp=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int seen;
        void'($urandom(32'd20240611));
        src_drq = 1'b1; dst_drq = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // Reset: parked, no interrupt
        chk(bus_req == 1'b0, "R7 bus idle after reset", 32'(bus_req), 0);
        chk(irq == 1'b0, "R9 irq low after reset", 32'(irq), 0);
        wr(2'd1, 20'h00100); wr(2'd3, 20'd4);
        idle(20);
        chk(xfers == 0, "R7 parked after reset", 32'(xfers), 0);
        src_drq = 1'b0; dst_drq = 1'b0;

        // Free running, word, src up / dst down, tc=0 int=1
        setup(mk_ctrl(0, 1, 0, 1, 0, 1, 0, 1, 2'b00, 0, 1), 20'h01000, 20'h02000, 16'd4);
        idle(25);
        chk(xfers == 4, "R5 free run stops at zero with tc=0", 32'(xfers), 4);
        chk(irq == 1'b0, "R9 no irq without tc", 32'(irq), 0);
        chk(exp_src == 20'h01008, "R3 word increment total", 32'(exp_src), 32'h01008);

        // Free running, byte, both addresses held, tc=1 int=1
        setup(mk_ctrl(1, 0, 0, 0, 1, 1, 1, 1, 2'b00, 0, 0), 20'hFFFFF, 20'h00003, 16'd3);
        idle(20);
        chk(xfers == 3, "R5 free run count 3", 32'(xfers), 3);
        chk(irq == 1'b1, "R9 irq at terminal count", 32'(irq), 1);
        idle(10);
        chk(irq == 1'b1, "R10 irq held", 32'(irq), 1);
        chk(xfers == 3, "R5 stays stopped", 32'(xfers), 3);
        pulse_ack();
        chk(irq == 1'b0, "R10 irq cleared by ack", 32'(irq), 0);

        // Source paced, tc=1 int=0
        setup(mk_ctrl(0, 0, 1, 1, 1, 0, 1, 0, 2'b01, 0, 1), 20'h00400, 20'h00800, 16'd5);
        dst_drq = 1'b1; tmr_drq = 1'b0;
        idle(12);
        chk(xfers == 0, "R6 source pacing ignores other lines", 32'(xfers), 0);
        src_drq = 1'b1;
        idle(30);
        chk(xfers == 5, "R6 source paced stops at zero with tc=1", 32'(xfers), 5);
        chk(irq == 1'b0, "R9 no irq without enable", 32'(irq), 0);
        src_drq = 1'b0; dst_drq = 1'b0;
        idle(4);

        // Destination paced, tc=0: runs past zero
        setup(mk_ctrl(1, 0, 1, 0, 0, 1, 0, 1, 2'b10, 0, 0), 20'h03000, 20'h04000, 16'd2);
        src_drq = 1'b1;
        idle(10);
        chk(xfers == 0, "R6 destination pacing ignores source line", 32'(xfers), 0);
        src_drq = 1'b0; dst_drq = 1'b1;
        idle(30);
        chk(xfers > 2, "R6 continues past zero with tc=0", 32'(xfers), 3);
        dst_drq = 1'b0;
        idle(6);
        seen = xfers;
        idle(12);
        chk(xfers == seen, "R6 stops when request drops", 32'(xfers), 32'(seen));
        chk(irq == 1'b0, "R9 no irq without tc in paced run", 32'(irq), 0);

        // Timer paced, sync code 11 ignored
        setup(mk_ctrl(0, 0, 1, 0, 0, 1, 1, 1, 2'b11, 1, 1), 20'h05000, 20'h06000, 16'd2);
        src_drq = 1'b1; dst_drq = 1'b1;
        idle(10);
        chk(xfers == 0, "R8 timer mode waits for timer line", 32'(xfers), 0);
        pulse_tmr(); idle(6);
        chk(xfers == 1, "R8 one timer request one transfer", 32'(xfers), 1);
        chk(irq == 1'b0, "R9 no irq before zero", 32'(irq), 0);
        pulse_tmr(); idle(6);
        chk(xfers == 2, "R8 second transfer", 32'(xfers), 2);
        chk(irq == 1'b1, "R9 irq in timer mode", 32'(irq), 1);
        pulse_tmr(); idle(6);
        chk(xfers == 2, "R8 stopped at zero", 32'(xfers), 2);
        wr(2'd0, 20'(mk_ctrl(0, 0, 1, 0, 0, 1, 1, 1, 2'b11, 1, 1)));
        chk(irq == 1'b0, "R10 control write clears irq", 32'(irq), 0);
        src_drq = 1'b0; dst_drq = 1'b0;

        // Random free-running runs
        for (int i = 0; i < 40; i++) begin
            logic [15:0] c;
            int n;
            bit tc, ie;
            tc = 1'($urandom); ie = 1'($urandom);
            n = 1 + int'($urandom % 6);
            c = mk_ctrl(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                        1'($urandom), tc, ie, 2'b00, 0, 1'($urandom));
            setup(c, 20'($urandom), 20'($urandom), 16'(n));
            idle(3 * n + 8);
            chk(xfers == n, "R5 random run length", 32'(xfers), 32'(n));
            chk(irq == (tc & ie), "R9 random irq", 32'(irq), 32'(tc & ie));
            if (irq) pulse_ack();
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule